// File: doc/BRIEF.md
# Character-Synchronous Sync Hunt Receiver

This receiver takes a serial bit stream, one bit per qualified receive-clock enable, and finds character boundaries before it frames any data. In internal mode it slides a window over the most recent bits. It looks for a programmed sync pattern, either a single character or a pair of characters in a row. In external mode, alignment comes from a strobe input instead. The sync-detect output stays high while the block is aligned. A host command sends the block back to the hunt.

Once aligned, the block builds characters of 5 to 8 bits, least significant bit first. When parity is enabled, a parity bit follows each character. Each finished character is placed in a one-deep receive buffer. The block raises a ready flag and records parity and overrun errors. Both error flags stay set until the host clears them.

Top module: `sync_hunt_rx`

## Requirements
- R1: After reset, sync_det, rx_ready, par_err and ovr_err are 0 and rd_data is 0.
- R2: Character length is 5 plus the value of cfg_len. Sync characters use the same length and are compared on their low bits. In internal mode (cfg_ext=0), each bit taken on bit_en enters a window of the last N bits, with the earliest bit in position 0. A match against sync_a is only accepted once at least N bits have been taken since reset or since hunt entry. With cfg_dual=0, a match sets sync_det from the next clock.
- R3: With cfg_dual=1, a sync_a match is followed by N bits that are compared with sync_b. If they are equal, the block locks. If they differ, it returns to the hunt with an empty window, and sync_det stays 0 throughout.
- R4: In external mode (cfg_ext=1), while hunting, ext_sync high at a bit_en locks the block, and the bit taken on that same enable is bit 0 of the first character. The sync pattern is never matched in this mode. ext_sync has no effect in internal mode or while locked.
- R5: When locked, each character is N data bits taken least significant bit first, then one parity bit if cfg_par_en=1. From the clock after the last bit, rd_data holds the data zero-extended and rx_ready is 1. Sync characters found during the hunt are not delivered.
- R6: Parity is even when cfg_par_odd=0 and odd when cfg_par_odd=1. The data bits and the parity bit together must hold an even or odd count of ones respectively. A mismatch sets par_err, which stays set until clr_err is pulsed.
- R7: rd_stb clears rx_ready on the next clock. If a character completes in the same cycle as rd_stb, rx_ready stays 1 and no overrun is flagged.
- R8: A character that completes while rx_ready is 1, with no rd_stb in that cycle, replaces rd_data and sets ovr_err. ovr_err stays set until clr_err is pulsed.
- R9: hunt_cmd makes sync_det 0 from the next clock and discards any partly built character. The window must then be refilled with N fresh bits before a match counts.
- R10: rx_bit has no effect in cycles where bit_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Qualified receive-clock enable, one bit per pulse |
| rx_bit | input | 1 | Serial data in |
| cfg_len | input | 2 | Character length minus 5 |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_dual | input | 1 | Require two sync characters |
| cfg_ext | input | 1 | Take alignment from ext_sync |
| ext_sync | input | 1 | External alignment strobe |
| sync_a | input | 8 | First sync character |
| sync_b | input | 8 | Second sync character |
| hunt_cmd | input | 1 | Pulse to re-enter the hunt |
| rd_stb | input | 1 | Host read of the receive buffer |
| clr_err | input | 1 | Clears par_err and ovr_err |
| rd_data | output | 8 | Receive buffer |
| rx_ready | output | 1 | Buffer holds an unread character |
| par_err | output | 1 | Sticky parity error |
| ovr_err | output | 1 | Sticky overrun error |
| sync_det | output | 1 | Aligned |

## Verification
The bench checks the sync pattern sent right after hunt entry. A design without window fill tracking would lock early on an all-zero pattern. A design that slid the window wrongly would lock a bit early or late.

In double mode, a wrong second character must return the block to the hunt. A design that locked on the first character alone would raise sync_det too soon. External alignment must take the strobed bit as data bit 0 and must ignore later strobes. A design that got either wrong would deliver a shifted character.

The bench also sends a read in the same cycle as a completing character and checks that no false overrun appears. It pulses hunt_cmd partway through a character and checks that the next delivered character is clean.

// File: rtl/sync_hunt_rx_pkg.sv
package sync_hunt_rx_pkg;
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_SYNC2 = 2'd1,
        ST_LOCK  = 2'd2
    } shr_state_e;
endpackage

// File: rtl/sync_hunt_rx_window.sv
// Sliding window of the most recent bits and sync pattern comparators.
module sync_hunt_rx_window #(
    parameter int MAX_W   = 8,
    parameter int LEN_W   = 2,
    parameter int MIN_LEN = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             rx_bit,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [MAX_W-1:0] sync_a,
    input  logic [MAX_W-1:0] sync_b,
    output logic             hit_a,
    output logic             hit_b
);
    localparam int CW = $clog2(MAX_W + 2);

    typedef struct packed {
        logic [MAX_W-1:0] win;
    } win_s;

    win_s             win_d, win_q;
    logic [CW-1:0]    len_w;
    logic [CW-1:0]    shamt;
    logic [MAX_W-1:0] win_nx;
    logic [MAX_W-1:0] aligned;
    logic [MAX_W-1:0] mask;

    always_comb begin
        win_d   = win_q;
        len_w   = CW'(MIN_LEN) + CW'(cfg_len);
        shamt   = CW'(MAX_W) - len_w;
        // newest bit enters at the top; the oldest of the last N ends in bit 0
        win_nx  = {rx_bit, win_q.win[MAX_W-1:1]};
        aligned = win_nx >> shamt;
        mask    = ~({MAX_W{1'b1}} << len_w);
        hit_a   = aligned == (sync_a & mask);
        hit_b   = aligned == (sync_b & mask);
        if (bit_en) begin
            win_d.win = win_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end
endmodule

// File: rtl/sync_hunt_rx_frame.sv
// Hunt / second-sync / locked sequencing and character assembly.
module sync_hunt_rx_frame
    import sync_hunt_rx_pkg::*;
#(
    parameter int MAX_W   = 8,
    parameter int LEN_W   = 2,
    parameter int MIN_LEN = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             rx_bit,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             cfg_par_en,
    input  logic             cfg_par_odd,
    input  logic             cfg_dual,
    input  logic             cfg_ext,
    input  logic             ext_sync,
    input  logic             hunt_cmd,
    input  logic             hit_a,
    input  logic             hit_b,
    output logic             done,
    output logic [MAX_W-1:0] done_data,
    output logic             done_perr,
    output logic             locked
);
    localparam int CW = $clog2(MAX_W + 2);
    localparam int IW = $clog2(MAX_W);

    typedef struct packed {
        shr_state_e       st;
        logic [CW-1:0]    cnt;
        logic [MAX_W-1:0] dat;
        logic             acc;
    } frm_s;

    frm_s             frm_d, frm_q;
    logic [CW-1:0]    len_w;
    logic [CW-1:0]    frm_w;
    logic [CW-1:0]    cnt_inc;
    logic [MAX_W-1:0] asm_dat;
    logic             asm_acc;

    always_comb begin
        frm_d     = frm_q;
        done      = 1'b0;
        done_perr = 1'b0;
        len_w     = CW'(MIN_LEN) + CW'(cfg_len);
        frm_w     = len_w + CW'(cfg_par_en);
        cnt_inc   = frm_q.cnt + 1'b1;
        asm_dat   = (frm_q.cnt == '0) ? '0 : frm_q.dat;
        asm_acc   = (frm_q.cnt == '0) ? 1'b0 : frm_q.acc;
        if (frm_q.cnt < len_w) begin
            asm_dat[frm_q.cnt[IW-1:0]] = rx_bit;
        end
        done_data = asm_dat;

        if (hunt_cmd) begin
            frm_d.st  = ST_HUNT;
            frm_d.cnt = '0;
            frm_d.acc = 1'b0;
        end else if (bit_en) begin
            case (frm_q.st)
                ST_HUNT: begin
                    if (cfg_ext) begin
                        if (ext_sync) begin
                            frm_d.st  = ST_LOCK;
                            frm_d.cnt = CW'(1);
                            frm_d.dat = MAX_W'(rx_bit);
                            frm_d.acc = rx_bit;
                        end
                    end else begin
                        if (frm_q.cnt < len_w) begin
                            frm_d.cnt = cnt_inc;
                        end
                        if (cnt_inc >= len_w && hit_a) begin
                            frm_d.cnt = '0;
                            frm_d.acc = 1'b0;
                            frm_d.st  = cfg_dual ? ST_SYNC2 : ST_LOCK;
                        end
                    end
                end
                ST_SYNC2: begin
                    frm_d.cnt = cnt_inc;
                    if (cnt_inc == len_w) begin
                        frm_d.cnt = '0;
                        frm_d.st  = hit_b ? ST_LOCK : ST_HUNT;
                    end
                end
                ST_LOCK: begin
                    frm_d.dat = asm_dat;
                    frm_d.acc = asm_acc ^ rx_bit;
                    frm_d.cnt = cnt_inc;
                    if (cnt_inc == frm_w) begin
                        done      = 1'b1;
                        done_perr = cfg_par_en && ((asm_acc ^ rx_bit) != cfg_par_odd);
                        frm_d.cnt = '0;
                    end
                end
                default: begin
                    frm_d.st  = ST_HUNT;
                    frm_d.cnt = '0;
                end
            endcase
        end
        locked = frm_q.st == ST_LOCK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q <= '{st: ST_HUNT, cnt: '0, dat: '0, acc: 1'b0};
        end else begin
            frm_q <= frm_d;
        end
    end
endmodule

// File: rtl/sync_hunt_rx_hold.sv
// One-deep receive buffer with ready and sticky error flags.
module sync_hunt_rx_hold #(
    parameter int MAX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic [MAX_W-1:0] done_data,
    input  logic             done_perr,
    input  logic             rd_stb,
    input  logic             clr_err,
    output logic [MAX_W-1:0] rd_data,
    output logic             rx_ready,
    output logic             par_err,
    output logic             ovr_err
);
    typedef struct packed {
        logic [MAX_W-1:0] data;
        logic             rdy;
        logic             perr;
        logic             ovr;
    } hold_s;

    hold_s hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (rd_stb) begin
            hold_d.rdy = 1'b0;
        end
        if (clr_err) begin
            hold_d.perr = 1'b0;
            hold_d.ovr  = 1'b0;
        end
        if (done) begin
            hold_d.data = done_data;
            hold_d.rdy  = 1'b1;
            if (hold_q.rdy && !rd_stb) begin
                hold_d.ovr = 1'b1;
            end
            if (done_perr) begin
                hold_d.perr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign rd_data  = hold_q.data;
    assign rx_ready = hold_q.rdy;
    assign par_err  = hold_q.perr;
    assign ovr_err  = hold_q.ovr;
endmodule

// File: rtl/sync_hunt_rx.sv
module sync_hunt_rx #(
    parameter int MAX_W   = 8,
    parameter int LEN_W   = 2,
    parameter int MIN_LEN = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             rx_bit,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             cfg_par_en,
    input  logic             cfg_par_odd,
    input  logic             cfg_dual,
    input  logic             cfg_ext,
    input  logic             ext_sync,
    input  logic [MAX_W-1:0] sync_a,
    input  logic [MAX_W-1:0] sync_b,
    input  logic             hunt_cmd,
    input  logic             rd_stb,
    input  logic             clr_err,
    output logic [MAX_W-1:0] rd_data,
    output logic             rx_ready,
    output logic             par_err,
    output logic             ovr_err,
    output logic             sync_det
);
    logic             hit_a;
    logic             hit_b;
    logic             frm_done;
    logic [MAX_W-1:0] frm_data;
    logic             frm_perr;

    sync_hunt_rx_window #(.MAX_W(MAX_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .rx_bit  (rx_bit),
        .cfg_len (cfg_len),
        .sync_a  (sync_a),
        .sync_b  (sync_b),
        .hit_a   (hit_a),
        .hit_b   (hit_b)
    );

    sync_hunt_rx_frame #(.MAX_W(MAX_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .rx_bit      (rx_bit),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .cfg_dual    (cfg_dual),
        .cfg_ext     (cfg_ext),
        .ext_sync    (ext_sync),
        .hunt_cmd    (hunt_cmd),
        .hit_a       (hit_a),
        .hit_b       (hit_b),
        .done        (frm_done),
        .done_data   (frm_data),
        .done_perr   (frm_perr),
        .locked      (sync_det)
    );

    sync_hunt_rx_hold #(.MAX_W(MAX_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (frm_done),
        .done_data (frm_data),
        .done_perr (frm_perr),
        .rd_stb    (rd_stb),
        .clr_err   (clr_err),
        .rd_data   (rd_data),
        .rx_ready  (rx_ready),
        .par_err   (par_err),
        .ovr_err   (ovr_err)
    );
endmodule

// File: rtl/sync_hunt_rx_chk.sv
module sync_hunt_rx_chk #(
    parameter int MAX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic             hunt_cmd,
    input logic             rd_stb,
    input logic             clr_err,
    input logic             done,
    input logic [MAX_W-1:0] rd_data,
    input logic             rx_ready,
    input logic             par_err,
    input logic             ovr_err,
    input logic             sync_det
);
    a_r5_done_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rx_ready);

    a_r5_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(rd_data));

    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !done) |=> !rx_ready);

    a_r6_perr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err && !clr_err) |=> par_err);

    a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_err && !clr_err) |=> ovr_err);

    a_r8_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_err) |-> $past(done && rx_ready && !rd_stb));

    a_r9_hunt_drops_sync: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_cmd |=> !sync_det);

    a_r10_lock_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_det) |-> $past(bit_en));
endmodule

bind sync_hunt_rx sync_hunt_rx_chk #(.MAX_W(MAX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .hunt_cmd (hunt_cmd),
    .rd_stb   (rd_stb),
    .clr_err  (clr_err),
    .done     (frm_done),
    .rd_data  (rd_data),
    .rx_ready (rx_ready),
    .par_err  (par_err),
    .ovr_err  (ovr_err),
    .sync_det (sync_det)
);

// File: tb/test_sync_hunt_rx.sv
module test_sync_hunt_rx;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0, rx_bit = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_dual = 1'b0, cfg_ext = 1'b0;
    logic       ext_sync = 1'b0;
    logic [7:0] sync_a = 8'h16, sync_b = 8'h69;
    logic       hunt_cmd = 1'b0, rd_stb = 1'b0, clr_err = 1'b0;
    logic [7:0] rd_data;
    logic       rx_ready, par_err, ovr_err, sync_det;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sync_hunt_rx i_sync_hunt_rx (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_dual(cfg_dual), .cfg_ext(cfg_ext), .ext_sync(ext_sync),
        .sync_a(sync_a), .sync_b(sync_b), .hunt_cmd(hunt_cmd),
        .rd_stb(rd_stb), .clr_err(clr_err), .rd_data(rd_data),
        .rx_ready(rx_ready), .par_err(par_err), .ovr_err(ovr_err),
        .sync_det(sync_det)
    );

    typedef struct packed {
        logic [1:0] len;
        logic       pe;
        logic       odd;
        logic       flip;
        logic [7:0] data;
        logic [7:0] exp;
        logic       perr;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{len: 2'd3, pe: 1'b0, odd: 1'b0, flip: 1'b0, data: 8'hA5, exp: 8'hA5, perr: 1'b0},
        '{len: 2'd0, pe: 1'b1, odd: 1'b0, flip: 1'b0, data: 8'hFF, exp: 8'h1F, perr: 1'b0},
        '{len: 2'd1, pe: 1'b1, odd: 1'b1, flip: 1'b0, data: 8'h2A, exp: 8'h2A, perr: 1'b0},
        '{len: 2'd2, pe: 1'b1, odd: 1'b0, flip: 1'b1, data: 8'h55, exp: 8'h55, perr: 1'b1},
        '{len: 2'd3, pe: 1'b1, odd: 1'b1, flip: 1'b1, data: 8'h80, exp: 8'h80, perr: 1'b1},
        '{len: 2'd0, pe: 1'b0, odd: 1'b1, flip: 1'b0, data: 8'h13, exp: 8'h13, perr: 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic rd);
        @(negedge clk);
        rx_bit = b;
        bit_en = 1'b1;
        rd_stb = rd;
        @(negedge clk);
        bit_en = 1'b0;
        rd_stb = 1'b0;
    endtask

    task automatic send_word(input logic [7:0] w, input int n);
        for (int i = 0; i < n; i++) send_bit(w[i], 1'b0);
    endtask

    task automatic send_frame(input logic [7:0] w, input int n, input logic pe,
                              input logic odd, input logic flip);
        logic p;
        p = odd ^ flip;
        for (int i = 0; i < n; i++) begin
            p = p ^ w[i];
            send_bit(w[i], 1'b0);
        end
        if (pe) send_bit(p, 1'b0);
    endtask

    task automatic pulse_hunt();
        @(negedge clk); hunt_cmd = 1'b1;
        @(negedge clk); hunt_cmd = 1'b0;
    endtask

    task automatic pulse_read();
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr_err = 1'b1;
        @(negedge clk); clr_err = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 sync_det", sync_det, 0);
        check("R1 rx_ready", rx_ready, 0);
        check("R1 errors", {par_err, ovr_err}, 0);
        check("R1 rd_data", rd_data, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Vector table: single sync, then one character
        for (int v = 0; v < 6; v++) begin
            int n;
            n = 5 + int'(VECS[v].len);
            cfg_len = VECS[v].len; cfg_par_en = VECS[v].pe; cfg_par_odd = VECS[v].odd;
            cfg_dual = 1'b0; cfg_ext = 1'b0; sync_a = 8'h16;
            pulse_hunt();
            send_word(8'h16, n - 1);
            check("R2 no lock before last sync bit", sync_det, 0);
            send_bit(sync_a[n-1], 1'b0);
            check("R2 lock on single sync", sync_det, 1);
            check("R5 sync not delivered", rx_ready, 0);
            send_frame(VECS[v].data, n, VECS[v].pe, VECS[v].odd, VECS[v].flip);
            check("R5 ready", rx_ready, 1);
            check("R5 data", rd_data, VECS[v].exp);
            check("R6 parity flag", par_err, VECS[v].perr);
            pulse_read();
            pulse_clr();
            check("R6 clr_err clears", par_err, 0);
        end

        // R2 window fill: all-zero sync must wait for N bits
        cfg_len = 2'd0; cfg_par_en = 1'b0; sync_a = 8'h00;
        pulse_hunt();
        send_word(8'h00, 4);
        check("R2 fill gate 4 zeros", sync_det, 0);
        send_bit(1'b0, 1'b0);
        check("R2 lock after 5 zeros", sync_det, 1);

        // R2 sliding search with leading junk, len 8
        cfg_len = 2'd3; sync_a = 8'h16;
        pulse_hunt();
        send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0);
        send_word(8'h16, 7);
        check("R2 slide no early lock", sync_det, 0);
        send_bit(1'b0, 1'b0);
        check("R2 slide lock", sync_det, 1);

        // R10 rx_bit ignored without bit_en
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); rx_bit = i[0];
        end
        check("R10 no character without bit_en", rx_ready, 0);
        send_frame(8'h5A, 8, 1'b0, 1'b0, 1'b0);
        check("R10 framing intact", rd_data, 8'h5A);
        pulse_read();
        check("R7 read clears ready", rx_ready, 0);

        // R8 overrun
        send_frame(8'h11, 8, 1'b0, 1'b0, 1'b0);
        send_frame(8'h22, 8, 1'b0, 1'b0, 1'b0);
        check("R8 overrun flag", ovr_err, 1);
        check("R8 newer data kept", rd_data, 8'h22);
        send_frame(8'h33, 7, 1'b0, 1'b0, 1'b0);
        send_bit(1'b0, 1'b1);
        // R7 read in the completion cycle: no further overrun, ready stays
        check("R7 ready kept on same-cycle read", rx_ready, 1);
        check("R7 data", rd_data, 8'h33);
        pulse_clr();
        check("R8 clr_err clears overrun", ovr_err, 0);
        send_frame(8'h44, 8, 1'b0, 1'b0, 1'b0);
        check("R7 same-cycle read left one pending", ovr_err, 1);
        pulse_read();
        pulse_clr();

        // R9 hunt_cmd mid character
        send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0);
        pulse_hunt();
        check("R9 sync_det dropped", sync_det, 0);
        send_word(8'h16, 8);
        check("R9 relock", sync_det, 1);
        send_frame(8'h0F, 8, 1'b0, 1'b0, 1'b0);
        check("R9 partial character discarded", rd_data, 8'h0F);
        check("R9 no overrun", ovr_err, 0);
        pulse_read();

        // R3 double sync
        cfg_dual = 1'b1; sync_b = 8'h69;
        pulse_hunt();
        send_word(8'h16, 8);
        check("R3 no lock after first sync", sync_det, 0);
        send_word(8'h68, 8);
        check("R3 wrong second sync", sync_det, 0);
        send_word(8'h16, 8);
        send_word(8'h69, 8);
        check("R3 lock on pair", sync_det, 1);
        check("R3 sync pair not delivered", rx_ready, 0);
        send_frame(8'hC7, 8, 1'b0, 1'b0, 1'b0);
        check("R3 data after pair", rd_data, 8'hC7);
        pulse_read();

        // R4 external alignment
        cfg_dual = 1'b0; cfg_ext = 1'b0;
        pulse_hunt();
        ext_sync = 1'b1;
        send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0);
        ext_sync = 1'b0;
        check("R4 ext_sync ignored in internal mode", sync_det, 0);
        cfg_ext = 1'b1;
        pulse_hunt();
        send_word(8'h16, 8);
        check("R4 no pattern match in external mode", sync_det, 0);
        ext_sync = 1'b1;
        send_bit(1'b0, 1'b0);
        ext_sync = 1'b0;
        check("R4 lock on strobe", sync_det, 1);
        for (int i = 1; i < 8; i++) send_bit(8'h3C >> i, 1'b0);
        check("R4 strobed bit is bit 0", rd_data, 8'h3C);
        pulse_read();
        ext_sync = 1'b1;
        send_frame(8'hC3, 8, 1'b0, 1'b0, 1'b0);
        ext_sync = 1'b0;
        check("R4 strobe ignored while locked", rd_data, 8'hC3);
        check("R4 ready", rx_ready, 1);

        finish_run();
    end
endmodule